// File: doc/BRIEF.md
# Two-Level Interrupt Event Router

This block gathers a wide bank of system event lines and funnels them onto a small set of level interrupt outputs for processor cores. Routing takes two programmable many-to-one steps. Each event first picks an intermediate channel. Each channel then picks an output line. Several events can share a channel, and several channels can share an output. Channel numbers and output numbers are independent of each other, so channel 9 may drive output 7.

Every event has an enable bit and a sticky pending bit. A rising edge on the event input sets the pending bit. Software clears it by writing ones. A fixed window of events, 16 to 31 by default, has no hardware source. Software raises those events to signal between cores. For each output, an index register reports which pending event has the highest priority. Applications program the maps when they start. When they stop, they write the map entries back to zero.

Registers are 32-bit words behind a simple write/read port. A read returns data one cycle after the address is presented.

Top module: `evt_router`

## Requirements
- R1: After reset, all channel-map fields, host-map fields, enable bits and pending bits read 0, `irq_out` is 0, and every index register reads 32'hFFFFFFFF.
- R2: Channel-map field widths and word locations:
  - Channel-map fields are 4 bits wide.
  - Word 0..7 holds events 8w..8w+7, and event 8w+k sits at bits 4k+3:4k.
  - Host-map words 8..9 hold channels the same way: channel c sits in word 8+c/8, nibble c%8.
  - Every map field reads back what was written.
- R3: A 0-to-1 transition on `ev_in[e]` sets pending bit e. The bit stays set while the input is held. A level that is still high after a clear does not set it again.
- R4: Pending bits are read and cleared at word 12 (events 0..31) and word 13 (events 32..63). Writing a 1 clears that bit. If a set and a clear hit the same bit in the same cycle, the set wins.
- R5: Writing a 1 to bit i of word 14 (events 0..31) or word 15 (events 32..63) sets pending for that event only when the event lies in 16..31. All other bits of those writes have no effect.
- R6: Enables are at word 10 (events 0..31) and word 11 (events 32..63). `irq_out[o]` is 1 when at least one event meets all of these conditions:
  - the event is both enabled and pending;
  - its channel's host map selects o.

  A pending event whose enable is 0 drives no output.
- R7: An event whose channel-map value is 10 or more is not routed. A channel whose host-map value is 10 or more is not routed.
- R8: The index register for output o is at word 16+o. Within one channel, the lowest-numbered enabled pending event is reported.
- R9: Among channels that drive the same output, the lowest-numbered active channel wins, regardless of the event numbers behind it.
- R10: An index register reads 32'hFFFFFFFF exactly when its output is low. Otherwise it reads the winning event number, zero-extended.
- R11: `irq_out` and the index registers change one clock after the register write or input edge that changes pending, enable or map state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_in | input | 64 | System event inputs, edge-detected |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data for `reg_addr` |
| irq_out | output | 10 | Level interrupt outputs |

## Verification
State errors in this block show up at the ports within two cycles:
- A pending bit that is stuck or lost shows up in the pending words on the next read. It also makes an `irq_out` line that should follow it stay high or stay low.
- A corrupted map field reads back wrong. It also sends an interrupt to the wrong line one cycle after the event becomes active.
- A wrong priority comparison shows in the index register, which names the wrong event. The directed scenarios load two competing events onto the same channel, or onto the same output through different channels, to expose this.
- Invalid map values, disabled events and the software-set window are each exercised so that a missing gate turns on an output that should stay low.

// File: rtl/evt_router_pkg.sv
package evt_router_pkg;
  localparam int MAP_W   = 4;   // width of every map field
  localparam int REG_W   = 32;  // register word width
  localparam int NIB_PER = REG_W / MAP_W;
endpackage

// File: rtl/evt_pending.sv
module evt_pending #(
  parameter int NUM_EVT = 64,
  parameter int SW_LO   = 16,
  parameter int SW_HI   = 31
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_EVT-1:0] ev_in,
  input  logic [NUM_EVT-1:0] sw_req,
  input  logic [NUM_EVT-1:0] clr_req,
  output logic [NUM_EVT-1:0] pend
);
  function automatic logic [NUM_EVT-1:0] mk_mask();
    logic [NUM_EVT-1:0] m;
    for (int i = 0; i < NUM_EVT; i++) m[i] = (i >= SW_LO) && (i <= SW_HI);
    return m;
  endfunction
  localparam logic [NUM_EVT-1:0] SW_MASK = mk_mask();

  logic [NUM_EVT-1:0] ev_q;
  logic [NUM_EVT-1:0] rise_v;
  logic [NUM_EVT-1:0] set_v;

  assign rise_v = ev_in & ~ev_q;
  assign set_v  = rise_v | (sw_req & SW_MASK);

  always_ff @(posedge clk) begin
    if (rst) begin
      ev_q <= '0;
      pend <= '0;
    end else begin
      ev_q <= ev_in;
      pend <= (pend & ~clr_req) | set_v;  // set wins over clear
    end
  end

  AST_EDGE_SETS: assert property (@(posedge clk) disable iff (rst)
    (rise_v != '0) |=> ((pend & $past(rise_v)) == $past(rise_v))); // R3
  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (rst)
    ((clr_req & ~set_v) != '0) |=> ((pend & $past(clr_req & ~set_v)) == '0)); // R4
  AST_SW_WINDOW: assert property (@(posedge clk) disable iff (rst)
    ((pend & ~$past(pend) & ~$past(rise_v) & ~SW_MASK) == '0)); // R5
endmodule

// File: rtl/evt_chan_stage.sv
module evt_chan_stage #(
  parameter int NUM_EVT   = 64,
  parameter int NUM_CHAN  = 10,
  parameter int EVT_IDX_W = 6
) (
  input  logic [NUM_EVT-1:0]             active,
  input  logic [evt_router_pkg::MAP_W-1:0] cmap [NUM_EVT],
  output logic [NUM_CHAN-1:0]            chan_act,
  output logic [EVT_IDX_W-1:0]           chan_evt [NUM_CHAN]
);
  // Lowest event number wins inside a channel; walk downward so it is kept last.
  always_comb begin
    for (int c = 0; c < NUM_CHAN; c++) begin
      chan_act[c] = 1'b0;
      chan_evt[c] = '0;
      for (int e = NUM_EVT - 1; e >= 0; e--) begin
        if (active[e] && (int'(cmap[e]) == c)) begin
          chan_act[c] = 1'b1;
          chan_evt[c] = EVT_IDX_W'(e);
        end
      end
    end
  end
endmodule

// File: rtl/evt_host_stage.sv
module evt_host_stage #(
  parameter int NUM_CHAN  = 10,
  parameter int NUM_OUT   = 10,
  parameter int EVT_IDX_W = 6
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic [NUM_CHAN-1:0]              chan_act,
  input  logic [EVT_IDX_W-1:0]             chan_evt [NUM_CHAN],
  input  logic [evt_router_pkg::MAP_W-1:0] hmap [NUM_CHAN],
  output logic [NUM_OUT-1:0]               irq_q,
  output logic [EVT_IDX_W-1:0]             idx_q [NUM_OUT]
);
  logic [NUM_OUT-1:0]   irq_d;
  logic [EVT_IDX_W-1:0] idx_d [NUM_OUT];

  // Lowest channel number wins inside an output.
  always_comb begin
    for (int o = 0; o < NUM_OUT; o++) begin
      irq_d[o] = 1'b0;
      idx_d[o] = '0;
      for (int c = NUM_CHAN - 1; c >= 0; c--) begin
        if (chan_act[c] && (int'(hmap[c]) == o)) begin
          irq_d[o] = 1'b1;
          idx_d[o] = chan_evt[c];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q <= '0;
      for (int o = 0; o < NUM_OUT; o++) idx_q[o] <= '0;
    end else begin
      irq_q <= irq_d;
      for (int o = 0; o < NUM_OUT; o++) idx_q[o] <= idx_d[o];
    end
  end

  AST_IRQ_NEEDS_CHAN: assert property (@(posedge clk) disable iff (rst)
    (irq_q != '0) |-> ($past(chan_act) != '0)); // R6
endmodule

// File: rtl/evt_router.sv
module evt_router #(
  parameter int NUM_EVT  = 64,
  parameter int NUM_CHAN = 10,
  parameter int NUM_OUT  = 10,
  parameter int SW_LO    = 16,
  parameter int SW_HI    = 31,
  parameter int ADDR_W   = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_EVT-1:0] ev_in,
  input  logic               reg_we,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  output logic [NUM_OUT-1:0] irq_out
);
  import evt_router_pkg::*;

  localparam int EVT_IDX_W  = $clog2(NUM_EVT);
  localparam int EVT_WORDS  = (NUM_EVT + REG_W - 1) / REG_W;
  localparam int CMAP_WORDS = (NUM_EVT + NIB_PER - 1) / NIB_PER;
  localparam int HMAP_WORDS = (NUM_CHAN + NIB_PER - 1) / NIB_PER;
  localparam int CMAP_BASE  = 0;
  localparam int HMAP_BASE  = CMAP_BASE + CMAP_WORDS;
  localparam int ENA_BASE   = HMAP_BASE + HMAP_WORDS;
  localparam int PEND_BASE  = ENA_BASE + EVT_WORDS;
  localparam int SWS_BASE   = PEND_BASE + EVT_WORDS;
  localparam int IDX_BASE   = SWS_BASE + EVT_WORDS;

  logic [MAP_W-1:0]     cmap [NUM_EVT];
  logic [MAP_W-1:0]     hmap [NUM_CHAN];
  logic [NUM_EVT-1:0]   en;
  logic [NUM_EVT-1:0]   pend;
  logic [NUM_EVT-1:0]   sw_req;
  logic [NUM_EVT-1:0]   clr_req;
  logic [NUM_CHAN-1:0]  chan_act;
  logic [EVT_IDX_W-1:0] chan_evt [NUM_CHAN];
  logic [EVT_IDX_W-1:0] idx_q [NUM_OUT];
  logic [31:0]          rd_next;
  int                   addr_i;

  assign addr_i = int'(reg_addr);

  // Configuration state
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int e = 0; e < NUM_EVT; e++) cmap[e] <= '0;
      for (int c = 0; c < NUM_CHAN; c++) hmap[c] <= '0;
      en <= '0;
    end else if (reg_we) begin
      for (int e = 0; e < NUM_EVT; e++) begin
        if (addr_i == CMAP_BASE + e / NIB_PER)
          cmap[e] <= reg_wdata[(e % NIB_PER) * MAP_W +: MAP_W];
        if (addr_i == ENA_BASE + e / REG_W)
          en[e] <= reg_wdata[e % REG_W];
      end
      for (int c = 0; c < NUM_CHAN; c++) begin
        if (addr_i == HMAP_BASE + c / NIB_PER)
          hmap[c] <= reg_wdata[(c % NIB_PER) * MAP_W +: MAP_W];
      end
    end
  end

  // Write-one strobes for pending set/clear
  always_comb begin
    for (int e = 0; e < NUM_EVT; e++) begin
      clr_req[e] = reg_we && (addr_i == PEND_BASE + e / REG_W) && reg_wdata[e % REG_W];
      sw_req[e]  = reg_we && (addr_i == SWS_BASE + e / REG_W) && reg_wdata[e % REG_W];
    end
  end

  evt_pending #(.NUM_EVT(NUM_EVT), .SW_LO(SW_LO), .SW_HI(SW_HI)) u_pend (
    .clk(clk), .rst(rst), .ev_in(ev_in),
    .sw_req(sw_req), .clr_req(clr_req), .pend(pend)
  );

  evt_chan_stage #(.NUM_EVT(NUM_EVT), .NUM_CHAN(NUM_CHAN), .EVT_IDX_W(EVT_IDX_W)) u_chan (
    .active(pend & en), .cmap(cmap), .chan_act(chan_act), .chan_evt(chan_evt)
  );

  evt_host_stage #(.NUM_CHAN(NUM_CHAN), .NUM_OUT(NUM_OUT), .EVT_IDX_W(EVT_IDX_W)) u_host (
    .clk(clk), .rst(rst), .chan_act(chan_act), .chan_evt(chan_evt),
    .hmap(hmap), .irq_q(irq_out), .idx_q(idx_q)
  );

  // Read mux
  always_comb begin
    rd_next = '0;
    for (int e = 0; e < NUM_EVT; e++) begin
      if (addr_i == CMAP_BASE + e / NIB_PER)
        rd_next[(e % NIB_PER) * MAP_W +: MAP_W] = cmap[e];
      if (addr_i == ENA_BASE + e / REG_W)  rd_next[e % REG_W] = en[e];
      if (addr_i == PEND_BASE + e / REG_W) rd_next[e % REG_W] = pend[e];
    end
    for (int c = 0; c < NUM_CHAN; c++) begin
      if (addr_i == HMAP_BASE + c / NIB_PER)
        rd_next[(c % NIB_PER) * MAP_W +: MAP_W] = hmap[c];
    end
    for (int o = 0; o < NUM_OUT; o++) begin
      if (addr_i == IDX_BASE + o)
        rd_next = irq_out[o] ? 32'(idx_q[o]) : '1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_next;
  end

  AST_OUT_FOLLOWS_ACTIVE: assert property (@(posedge clk) disable iff (rst)
    ($past((pend & en) == '0) && !$past(rst)) |-> (irq_out == '0)); // R6
  AST_RESET_QUIET: assert property (@(posedge clk)
    $past(rst) |-> (irq_out == '0)); // R1
endmodule

// File: tb/evt_router_bench.sv
module evt_router_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] ev_in = '0;
  logic        reg_we = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [9:0]  irq_out;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;  // 250 MHz

  evt_router u_evt_router (
    .clk(clk), .rst(rst), .ev_in(ev_in), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_out(irq_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; ev_in = '0; reg_we = 1'b0;
    cyc(3);
    rst = 1'b0;
    cyc(1);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    do_reset();
    chk("R1 irq", 32'(irq_out), 32'h0);
    for (int w = 0; w < 14; w++) begin
      rd(5'(w), d);
      chk("R1 cfg word", d, 32'h0);
    end
    for (int o = 0; o < 10; o++) begin
      rd(5'(16 + o), d);
      chk("R1 index", d, 32'hFFFF_FFFF);
    end
  endtask

  task automatic t_layout();
    logic [31:0] d;
    do_reset();
    wr(5'd2, 32'h7654_3210);
    wr(5'd9, 32'h0000_00A5);
    rd(5'd2, d); chk("R2 cmap word", d, 32'h7654_3210);
    rd(5'd9, d); chk("R2 hmap word", d, 32'h0000_00A5);
    // event 17 is nibble 1 of word 2 -> channel 1, host of ch1 is 0
    wr(5'd10, 32'h0002_0000);
    wr(5'd14, 32'h0002_0000);
    cyc(1);
    chk("R2 routed via nibble", 32'(irq_out), 32'h001);
    // teardown returns maps to zero
    wr(5'd2, 32'h0); wr(5'd9, 32'h0);
    rd(5'd2, d); chk("R2 teardown cmap", d, 32'h0);
    rd(5'd9, d); chk("R2 teardown hmap", d, 32'h0);
  endtask

  task automatic t_edge();
    logic [31:0] d;
    do_reset();
    wr(5'd5, 32'h0000_0003);   // event 40 -> ch3
    wr(5'd8, 32'h0000_5000);   // ch3 -> out5
    wr(5'd11, 32'h0000_0100);  // enable 40
    ev_in[40] = 1'b1;
    cyc(2);
    chk("R6 out5 asserted", 32'(irq_out), 32'h020);
    rd(5'd21, d); chk("R3 index of out5", d, 32'd40);
    wr(5'd13, 32'h0000_0100);
    chk("R11 one-cycle lag", 32'(irq_out), 32'h020);
    cyc(1);
    chk("R4 cleared out low", 32'(irq_out), 32'h000);
    rd(5'd13, d); chk("R3 held level no re-set", d, 32'h0);
    ev_in[40] = 1'b0; cyc(1); ev_in[40] = 1'b1; cyc(1);
    rd(5'd13, d); chk("R3 new edge sets", d, 32'h0000_0100);
  endtask

  task automatic t_enable();
    logic [31:0] d;
    do_reset();
    wr(5'd5, 32'h0000_0003);
    wr(5'd8, 32'h0000_5000);
    ev_in[40] = 1'b1;
    cyc(2);
    rd(5'd13, d); chk("R6 pending while disabled", d, 32'h0000_0100);
    chk("R6 disabled no irq", 32'(irq_out), 32'h0);
    wr(5'd11, 32'h0000_0100);
    cyc(1);
    chk("R6 enable drives out5", 32'(irq_out), 32'h020);
    // set and clear in same cycle: set wins
    ev_in[40] = 1'b0; cyc(1);
    ev_in[40] = 1'b1;
    wr(5'd13, 32'h0000_0100);
    rd(5'd13, d); chk("R4 set wins", d, 32'h0000_0100);
  endtask

  task automatic t_sw();
    logic [31:0] d;
    do_reset();
    wr(5'd14, 32'hFFFF_FFFF);
    wr(5'd15, 32'hFFFF_FFFF);
    rd(5'd12, d); chk("R5 sw window low", d, 32'hFFFF_0000);
    rd(5'd13, d); chk("R5 sw ignored high", d, 32'h0);
    wr(5'd12, 32'hFFFF_FFFF);
    rd(5'd12, d); chk("R4 w1c all", d, 32'h0);
  endtask

  task automatic t_invalid();
    logic [31:0] d;
    do_reset();
    wr(5'd2, 32'h000C_0000);   // event 20 -> ch12 (invalid)
    wr(5'd10, 32'h0010_0000);
    wr(5'd14, 32'h0010_0000);
    cyc(1);
    chk("R7 bad channel", 32'(irq_out), 32'h0);
    rd(5'd16, d); chk("R7 bad channel idx", d, 32'hFFFF_FFFF);
    wr(5'd2, 32'h0009_0000);   // event 20 -> ch9
    wr(5'd9, 32'h0000_00B0);   // ch9 -> host 11 (invalid)
    cyc(1);
    chk("R7 bad host", 32'(irq_out), 32'h0);
    wr(5'd9, 32'h0000_0070);   // ch9 -> out7
    cyc(1);
    chk("R7 valid route", 32'(irq_out), 32'h080);
    rd(5'd23, d); chk("R10 index out7", d, 32'd20);
  endtask

  task automatic t_prio_chan();
    logic [31:0] d;
    do_reset();
    wr(5'd2, 32'h0020_0000);   // event 21 -> ch2
    wr(5'd3, 32'h0000_0020);   // event 25 -> ch2
    wr(5'd8, 32'h0000_0200);   // ch2 -> out2
    wr(5'd10, 32'h0220_0000);
    wr(5'd14, 32'h0220_0000);
    cyc(1);
    rd(5'd18, d); chk("R8 lower event wins", d, 32'd21);
    wr(5'd12, 32'h0020_0000);
    cyc(1);
    rd(5'd18, d); chk("R8 next event", d, 32'd25);
    chk("R6 out2 still", 32'(irq_out), 32'h004);
  endtask

  task automatic t_prio_out();
    logic [31:0] d;
    do_reset();
    wr(5'd0, 32'h0060_0000);   // event 5 -> ch6
    wr(5'd6, 32'h0000_0100);   // event 50 -> ch1
    wr(5'd8, 32'h0400_0040);   // ch1,ch6 -> out4
    wr(5'd10, 32'h0000_0020);
    wr(5'd11, 32'h0004_0000);
    ev_in[5] = 1'b1; ev_in[50] = 1'b1;
    cyc(2);
    rd(5'd20, d); chk("R9 lower channel wins", d, 32'd50);
    wr(5'd13, 32'h0004_0000);
    cyc(1);
    rd(5'd20, d); chk("R9 fallback channel", d, 32'd5);
    wr(5'd12, 32'h0000_0020);
    cyc(1);
    rd(5'd20, d); chk("R10 none pending", d, 32'hFFFF_FFFF);
    chk("R10 out low", 32'(irq_out), 32'h0);
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_layout();
    t_edge();
    t_enable();
    t_sw();
    t_invalid();
    t_prio_chan();
    t_prio_out();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule